// File: doc/BRIEF.md
# Variable-Width Processor Register File

This block holds the architectural state of an 8/16-bit hybrid processor core: an accumulator, two index registers, a stack pointer, a direct-page base, a data bank and a program bank register, a program counter, an 8-bit status register and a hidden emulation latch. Two width flags in the status register and the emulation latch set whether the accumulator and the index registers behave as 8-bit or 16-bit registers. The write and read behaviour of the registers changes with this mode.

A single write port takes a target select and a 16-bit value. A single-flag port sets or clears one status bit. A flag-update port loads N and Z from a result, measured at accumulator width or at index width. Every register is visible on the outputs at all times. The accumulator and index registers are shown masked to the active width, and the full accumulator is also brought out. The surrounding core issues the requests. Decode, arithmetic, bus traffic and vector fetch are not part of this block.

Top module: `hybRegFile`

## Requirements
- R1: The status byte has C at bit 0, Z at bit 1, I at bit 2, D at bit 3, X at bit 4, M at bit 5, V at bit 6 and N at bit 7. Outside emulation, a status write (select 8, data bits 7:0) reads back as the same eight bits.
- R2: `acc8` is 1 when M or the emulation latch is set. `idx8` is 1 when X or the emulation latch is set.
- R3: When `acc8` is 1, an accumulator write (select 0) replaces only bits 7:0 and keeps the stored bits 15:8. `accView` then shows the low byte with the upper byte zero, and `accFull` shows all 16 stored bits.
- R4: When `idx8` is 1, a write to X (select 1) or Y (select 2) stores the low byte and zeroes the high byte. The views show only the low byte.
- R5: A flag-update request sets Z when the result at the selected width is zero. It copies bit 7 (8-bit width) or bit 15 (16-bit width) into N. `nzUseIdx` = 0 selects accumulator width and 1 selects index width. No other status bit changes.
- R6: After reset the emulation latch is 1, the status byte is 0x34, the stack pointer is 0x01FF, and every other register is 0.
- R7: While the emulation latch is set, or on the edge that sets it (select 9, data bit 0), status bits M and X are forced to 1 and the stack pointer high byte is forced to 0x01, whatever is written.
- R8: The single-flag port changes only the status bit at `flagIdx` to `flagVal` in one cycle.
- R9: On the edge where `idx8` goes from 0 to 1, the high bytes of X and Y are cleared.
- R10: An explicit status write in the same cycle as a flag-update or single-flag request wins, and those requests are dropped. Without a status write, both requests apply, and the single-flag value wins on its own bit.
- R11: In 16-bit mode, writes to the accumulator, X and Y store all 16 bits. Selects 3 (stack), 4 (direct page) and 7 (program counter) store 16 bits. Selects 5 (data bank) and 6 (program bank) store data bits 7:0. Select codes 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 4 | Write target select |
| wrData | input | 16 | Write value |
| flagEn | input | 1 | Single-flag strobe |
| flagIdx | input | 3 | Status bit position to change |
| flagVal | input | 1 | New value of that bit |
| nzEn | input | 1 | N/Z update strobe |
| nzUseIdx | input | 1 | Width select for N/Z: 0 accumulator, 1 index |
| nzResult | input | 16 | Result that N/Z are taken from |
| accView | output | 16 | Accumulator at active width |
| accFull | output | 16 | All stored accumulator bits |
| xView | output | 16 | X at active width |
| yView | output | 16 | Y at active width |
| spOut | output | 16 | Stack pointer |
| dpOut | output | 16 | Direct-page base |
| dbankOut | output | 8 | Data bank |
| pbankOut | output | 8 | Program bank |
| pcOut | output | 16 | Program counter |
| statusOut | output | 8 | Status byte |
| emuOut | output | 1 | Emulation latch |
| acc8 | output | 1 | Accumulator is 8-bit |
| idx8 | output | 1 | Index registers are 8-bit |

## Verification
The assertions assume that the write, flag and N/Z inputs are driven to known values from the first clock edge after reset, since their properties sample these inputs one cycle back. The bench holds every strobe low through reset. It changes inputs only just after a rising edge, so every request is stable for one full cycle. Concurrent requests, such as a status write together with a flag update, are issued on purpose in a single cycle, to exercise the priority rule and not to break any assumption.

// File: rtl/regFilePkg.sv
package regFilePkg;

  // status bit positions
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_I = 2;
  localparam int FLAG_D = 3;
  localparam int FLAG_X = 4;
  localparam int FLAG_M = 5;
  localparam int FLAG_V = 6;
  localparam int FLAG_N = 7;

  typedef enum logic [3:0] {
    SEL_ACC   = 4'd0,
    SEL_X     = 4'd1,
    SEL_Y     = 4'd2,
    SEL_SP    = 4'd3,
    SEL_DP    = 4'd4,
    SEL_DBANK = 4'd5,
    SEL_PBANK = 4'd6,
    SEL_PC    = 4'd7,
    SEL_STAT  = 4'd8,
    SEL_EMU   = 4'd9
  } regSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrAcc;
    logic       accNarrow;
    logic [1:0] wrIdx;
    logic       idxNarrow;
    logic       clrIdxHigh;
    logic       wrSp;
    logic       spPin;
    logic       wrDp;
    logic       wrDbank;
    logic       wrPbank;
    logic       wrPc;
  } strobeT;

endpackage

// File: rtl/regFileCtrl.sv
module regFileCtrl
  import regFilePkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          BYTE_W       = 8,
  parameter logic [7:0]  RESET_STATUS = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [7:0]        statusData,
  input  logic              flagEn,
  input  logic [2:0]        flagIdx,
  input  logic              flagVal,
  input  logic              nzEn,
  input  logic              nzUseIdx,
  input  logic [DATA_W-1:0] nzResult,
  output strobeT            strobe,
  output logic [7:0]        statusQ,
  output logic              emuQ,
  output logic              acc8,
  output logic              idx8
);

  localparam logic [7:0] WIDTH_MASK = (8'(1) << FLAG_X) | (8'(1) << FLAG_M);

  regSelE     sel;
  logic       stWr;
  logic       emuWr;
  logic       emuNext;
  logic [7:0] statusPre;
  logic [7:0] statusNext;
  logic       idx8Next;
  logic       nzNarrow;
  logic       nzZero;
  logic       nzNeg;

  assign sel  = regSelE'(wrSel);
  assign acc8 = emuQ | statusQ[FLAG_M];
  assign idx8 = emuQ | statusQ[FLAG_X];

  // N/Z at the selected width
  assign nzNarrow = nzUseIdx ? idx8 : acc8;
  assign nzZero   = nzNarrow ? (nzResult[BYTE_W-1:0] == '0) : (nzResult == '0);
  assign nzNeg    = nzNarrow ? nzResult[BYTE_W-1] : nzResult[DATA_W-1];

  always_comb begin
    strobe     = '0;
    stWr       = 1'b0;
    emuWr      = 1'b0;
    if (wrEn) begin
      case (sel)
        SEL_ACC:   strobe.wrAcc    = 1'b1;
        SEL_X:     strobe.wrIdx[0] = 1'b1;
        SEL_Y:     strobe.wrIdx[1] = 1'b1;
        SEL_SP:    strobe.wrSp     = 1'b1;
        SEL_DP:    strobe.wrDp     = 1'b1;
        SEL_DBANK: strobe.wrDbank  = 1'b1;
        SEL_PBANK: strobe.wrPbank  = 1'b1;
        SEL_PC:    strobe.wrPc     = 1'b1;
        SEL_STAT:  stWr            = 1'b1;
        SEL_EMU:   emuWr           = 1'b1;
        default:   ;
      endcase
    end
    strobe.accNarrow = acc8;
    strobe.idxNarrow = idx8;
    strobe.clrIdxHigh = idx8Next & ~idx8;
    strobe.spPin     = emuNext;
  end

  assign emuNext = emuWr ? statusData[0] : emuQ;

  always_comb begin
    if (stWr) begin
      statusPre = statusData;
    end else begin
      statusPre = statusQ;
      if (nzEn) begin
        statusPre[FLAG_Z] = nzZero;
        statusPre[FLAG_N] = nzNeg;
      end
      if (flagEn) statusPre[flagIdx] = flagVal;
    end
  end

  assign statusNext = emuNext ? (statusPre | WIDTH_MASK) : statusPre;
  assign idx8Next   = emuNext | statusNext[FLAG_X];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= RESET_STATUS;
      emuQ    <= 1'b1;
    end else begin
      statusQ <= statusNext;
      emuQ    <= emuNext;
    end
  end

  // R7
  emu_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    emuQ |-> (statusQ[FLAG_M] && statusQ[FLAG_X]));

  // R10
  status_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWr |=> statusQ == ($past(statusData) | ($past(emuQ) ? WIDTH_MASK : 8'h00)));

  // R5
  nz_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nzEn && !stWr && !flagEn && !nzUseIdx && !acc8 && !emuWr)
      |=> statusQ[FLAG_N] == $past(nzResult[DATA_W-1]));

endmodule

// File: rtl/regFileData.sv
module regFileData
  import regFilePkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          BYTE_W     = 8,
  parameter int          STACK_PAGE = 1,
  parameter logic [15:0] RESET_SP   = 16'h01FF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strobe,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   emuIn,
  input  logic                   idx8In,
  output logic [DATA_W-1:0]      accView,
  output logic [DATA_W-1:0]      accFull,
  output logic [1:0][DATA_W-1:0] idxView,
  output logic [DATA_W-1:0]      spOut,
  output logic [DATA_W-1:0]      dpOut,
  output logic [BYTE_W-1:0]      dbankOut,
  output logic [BYTE_W-1:0]      pbankOut,
  output logic [DATA_W-1:0]      pcOut
);

  localparam int HIGH_W = DATA_W - BYTE_W;
  localparam logic [HIGH_W-1:0] PAGE_HI = HIGH_W'(STACK_PAGE);

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] spQ;
  logic [DATA_W-1:0] spD;
  logic [DATA_W-1:0] dpQ;
  logic [BYTE_W-1:0] dbankQ;
  logic [BYTE_W-1:0] pbankQ;
  logic [DATA_W-1:0] pcQ;

  // accumulator: hidden high byte survives narrow writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strobe.wrAcc) begin
      if (strobe.accNarrow) accQ <= {accQ[DATA_W-1:BYTE_W], wrData[BYTE_W-1:0]};
      else                  accQ <= wrData;
    end
  end

  assign accFull = accQ;
  assign accView = strobe.accNarrow ? {{HIGH_W{1'b0}}, accQ[BYTE_W-1:0]} : accQ;

  // index registers
  for (genvar g = 0; g < 2; g++) begin : gIdx
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    always_comb begin
      d = q;
      if (strobe.wrIdx[g]) begin
        d = strobe.idxNarrow ? {{HIGH_W{1'b0}}, wrData[BYTE_W-1:0]} : wrData;
      end
      if (strobe.clrIdxHigh) d[DATA_W-1:BYTE_W] = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= d;
    end

    assign idxView[g] = strobe.idxNarrow ? {{HIGH_W{1'b0}}, q[BYTE_W-1:0]} : q;

    // R9
    idx_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      idx8In |-> (q[DATA_W-1:BYTE_W] == '0));
  end

  // stack pointer, page pinned in emulation
  always_comb begin
    spD = strobe.wrSp ? wrData : spQ;
    if (strobe.spPin) spD[DATA_W-1:BYTE_W] = PAGE_HI;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ    <= DATA_W'(RESET_SP);
      dpQ    <= '0;
      dbankQ <= '0;
      pbankQ <= '0;
      pcQ    <= '0;
    end else begin
      spQ <= spD;
      if (strobe.wrDp)    dpQ    <= wrData;
      if (strobe.wrDbank) dbankQ <= wrData[BYTE_W-1:0];
      if (strobe.wrPbank) pbankQ <= wrData[BYTE_W-1:0];
      if (strobe.wrPc)    pcQ    <= wrData;
    end
  end

  assign spOut    = spQ;
  assign dpOut    = dpQ;
  assign dbankOut = dbankQ;
  assign pbankOut = pbankQ;
  assign pcOut    = pcQ;

  // R7
  emu_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    emuIn |-> (spQ[DATA_W-1:BYTE_W] == PAGE_HI));

  // R3
  acc_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrAcc && strobe.accNarrow)
      |=> accQ[DATA_W-1:BYTE_W] == $past(accQ[DATA_W-1:BYTE_W]));

endmodule

// File: rtl/hybRegFile.sv
module hybRegFile
  import regFilePkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          BYTE_W       = 8,
  parameter int          STACK_PAGE   = 1,
  parameter logic [15:0] RESET_SP     = 16'h01FF,
  parameter logic [7:0]  RESET_STATUS = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flagEn,
  input  logic [2:0]        flagIdx,
  input  logic              flagVal,
  input  logic              nzEn,
  input  logic              nzUseIdx,
  input  logic [DATA_W-1:0] nzResult,
  output logic [DATA_W-1:0] accView,
  output logic [DATA_W-1:0] accFull,
  output logic [DATA_W-1:0] xView,
  output logic [DATA_W-1:0] yView,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] dpOut,
  output logic [BYTE_W-1:0] dbankOut,
  output logic [BYTE_W-1:0] pbankOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [7:0]        statusOut,
  output logic              emuOut,
  output logic              acc8,
  output logic              idx8
);

  strobeT                 strobe;
  logic [1:0][DATA_W-1:0] idxView;

  regFileCtrl #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .RESET_STATUS(RESET_STATUS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .statusData(wrData[7:0]), .flagEn(flagEn), .flagIdx(flagIdx),
    .flagVal(flagVal), .nzEn(nzEn), .nzUseIdx(nzUseIdx),
    .nzResult(nzResult), .strobe(strobe), .statusQ(statusOut),
    .emuQ(emuOut), .acc8(acc8), .idx8(idx8)
  );

  regFileData #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .STACK_PAGE(STACK_PAGE), .RESET_SP(RESET_SP)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .emuIn(emuOut), .idx8In(idx8), .accView(accView), .accFull(accFull),
    .idxView(idxView), .spOut(spOut), .dpOut(dpOut), .dbankOut(dbankOut),
    .pbankOut(pbankOut), .pcOut(pcOut)
  );

  assign xView = idxView[0];
  assign yView = idxView[1];

endmodule

// File: tb/hybRegFile_tb_top.sv
module hybRegFile_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        flagEn = 1'b0;
  logic [2:0]  flagIdx = '0;
  logic        flagVal = 1'b0;
  logic        nzEn = 1'b0;
  logic        nzUseIdx = 1'b0;
  logic [15:0] nzResult = '0;
  logic [15:0] accView, accFull, xView, yView, spOut, dpOut, pcOut;
  logic [7:0]  dbankOut, pbankOut, statusOut;
  logic        emuOut, acc8, idx8;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hybRegFile dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .flagEn(flagEn), .flagIdx(flagIdx), .flagVal(flagVal), .nzEn(nzEn),
    .nzUseIdx(nzUseIdx), .nzResult(nzResult), .accView(accView),
    .accFull(accFull), .xView(xView), .yView(yView), .spOut(spOut),
    .dpOut(dpOut), .dbankOut(dbankOut), .pbankOut(pbankOut), .pcOut(pcOut),
    .statusOut(statusOut), .emuOut(emuOut), .acc8(acc8), .idx8(idx8)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // one cycle, inputs changed 1 time unit after the edge
  task automatic step();
    @(posedge clk);
    #1;
    wrEn = 1'b0; flagEn = 1'b0; nzEn = 1'b0;
  endtask

  task automatic regWrite(logic [3:0] sel, logic [15:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    step();
  endtask

  task automatic flagSet(int idx, logic val);
    flagEn = 1'b1; flagIdx = 3'(idx); flagVal = val;
    step();
  endtask

  task automatic nzUpdate(logic useIdx, logic [15:0] res);
    nzEn = 1'b1; nzUseIdx = useIdx; nzResult = res;
    step();
  endtask

  task automatic testReset();
    check("R6 status", 16'(statusOut), 16'h0034);
    check("R6 emu", 16'(emuOut), 16'h1);
    check("R6 sp", spOut, 16'h01FF);
    check("R6 acc", accFull, 16'h0);
    check("R6 x", xView, 16'h0);
    check("R6 y", yView, 16'h0);
    check("R6 dp", dpOut, 16'h0);
    check("R6 banks", {dbankOut, pbankOut}, 16'h0);
    check("R6 pc", pcOut, 16'h0);
    check("R2 reset widths", {14'h0, acc8, idx8}, 16'h3);
  endtask

  task automatic testEmuForce();
    regWrite(4'd3, 16'h1234);
    check("R7 sp page pinned", spOut, 16'h0134);
    regWrite(4'd8, 16'h0000);
    check("R7 width bits forced", 16'(statusOut), 16'h0030);
    regWrite(4'd9, 16'h0000);
    check("R7 emu cleared", 16'(emuOut), 16'h0);
    check("R2 M still 8-bit", 16'(acc8), 16'h1);
    regWrite(4'd8, 16'h0000);
    check("R2 native 16-bit", {14'h0, acc8, idx8}, 16'h0);
  endtask

  task automatic testWide();
    regWrite(4'd0, 16'hBEEF);
    regWrite(4'd1, 16'h1234);
    regWrite(4'd2, 16'hABCD);
    check("R11 acc wide", accView, 16'hBEEF);
    check("R11 x wide", xView, 16'h1234);
    check("R11 y wide", yView, 16'hABCD);
  endtask

  task automatic testAccNarrow();
    flagSet(5, 1'b1);
    check("R8 set M", 16'(statusOut), 16'h0020);
    check("R3 view masked", accView, 16'h00EF);
    regWrite(4'd0, 16'h0055);
    check("R3 high kept", accFull, 16'hBE55);
    check("R3 view", accView, 16'h0055);
  endtask

  task automatic testIdxNarrow();
    flagSet(4, 1'b1);
    check("R9 x high cleared", xView, 16'h0034);
    check("R9 y high cleared", yView, 16'h00CD);
    flagSet(4, 1'b0);
    check("R9 x stays cleared", xView, 16'h0034);
    flagSet(4, 1'b1);
    regWrite(4'd1, 16'hFF77);
    check("R4 x view", xView, 16'h0077);
    flagSet(4, 1'b0);
    check("R4 x high zero", xView, 16'h0077);
    check("R8 status", 16'(statusOut), 16'h0020);
  endtask

  task automatic testNz();
    nzUpdate(1'b0, 16'h1200);
    check("R5 acc8 zero", 16'(statusOut), 16'h0022);
    nzUpdate(1'b0, 16'h0080);
    check("R5 acc8 neg", 16'(statusOut), 16'h00A0);
    nzUpdate(1'b1, 16'h0080);
    check("R5 idx16 pos", 16'(statusOut), 16'h0020);
    nzUpdate(1'b1, 16'h8000);
    check("R5 idx16 neg", 16'(statusOut), 16'h00A0);
    nzUpdate(1'b1, 16'h0000);
    check("R5 idx16 zero", 16'(statusOut), 16'h0022);
  endtask

  task automatic testPriority();
    wrEn = 1'b1; wrSel = 4'd8; wrData = 16'h0041;
    nzEn = 1'b1; nzUseIdx = 1'b1; nzResult = 16'h8000;
    flagEn = 1'b1; flagIdx = 3'd7; flagVal = 1'b1;
    step();
    check("R10 status write wins", 16'(statusOut), 16'h0041);
    flagSet(3, 1'b1);
    check("R8 set D only", 16'(statusOut), 16'h0049);
    flagSet(0, 1'b0);
    check("R8 clear C only", 16'(statusOut), 16'h0048);
  endtask

  task automatic testRoundTrip();
    regWrite(4'd8, 16'h00CF);
    check("R1 round trip", 16'(statusOut), 16'h00CF);
    regWrite(4'd8, 16'h0048);
    flagSet(5, 1'b1);
    check("R2 M only", {14'h0, acc8, idx8}, 16'h2);
    flagSet(5, 1'b0);
    check("R1 status back", 16'(statusOut), 16'h0048);
  endtask

  task automatic testOtherRegs();
    regWrite(4'd1, 16'h5678);
    regWrite(4'd4, 16'h2000);
    regWrite(4'd5, 16'h0A7E);
    regWrite(4'd6, 16'h3412);
    regWrite(4'd7, 16'hC0DE);
    regWrite(4'd3, 16'h1FF0);
    check("R11 x", xView, 16'h5678);
    check("R11 dp", dpOut, 16'h2000);
    check("R11 dbank", 16'(dbankOut), 16'h007E);
    check("R11 pbank", 16'(pbankOut), 16'h0012);
    check("R11 pc", pcOut, 16'hC0DE);
    check("R11 sp native", spOut, 16'h1FF0);
    regWrite(4'd15, 16'hFFFF);
    check("R11 unused select acc", accView, 16'hBE55);
    check("R11 unused select status", 16'(statusOut), 16'h0048);
    check("R11 unused select pc", pcOut, 16'hC0DE);
  endtask

  task automatic testEmuEnter();
    regWrite(4'd9, 16'h0001);
    check("R7 emu set", 16'(emuOut), 16'h1);
    check("R7 widths forced", 16'(statusOut), 16'h0078);
    check("R7 sp pinned on entry", spOut, 16'h01F0);
    check("R9 x narrowed on entry", xView, 16'h0078);
    check("R2 emu widths", {14'h0, acc8, idx8}, 16'h3);
    check("R3 acc view", accView, 16'h0055);
    check("R3 acc full", accFull, 16'hBE55);
    regWrite(4'd3, 16'hABCD);
    check("R7 sp write pinned", spOut, 16'h01CD);
    flagSet(5, 1'b0);
    check("R7 M flag held", 16'(statusOut), 16'h0078);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    testReset();
    testEmuForce();
    testWide();
    testAccNarrow();
    testIdxNarrow();
    testNz();
    testPriority();
    testRoundTrip();
    testOtherRegs();
    testEmuEnter();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule